// File: doc/BRIEF.md
# Page Access Permission Evaluator

This block decides what a translated memory access may do to its page. The translation unit presents, in a single request cycle, the problem-state flag, the protection bits of the matching segment, the protection fields of the page-table entry, the two per-key mask registers and the kind of access. One clock later the block returns the read, write and execute rights for the page. It also returns a fault flag with syndrome bits that name each source that refused the access, and requests to mark the entry as referenced or changed.

Three sources set the rights, and the granted rights are their intersection. The first is a decode table indexed by the storage key and the 3-bit page-protection code. The second is the no-execute and guard bits. The third is the access-mask and instruction-access-mask pair selected by the entry's key. The caller uses the fault syndrome to raise the right exception. It uses the referenced and changed requests to update the entry in memory. The block performs neither the memory update nor the lookup.

Top module: `page_rights_eval`

## Requirements
- R1: The storage key used for decoding is `seg_kp` when `prob_state` is 1 and `seg_ks` when it is 0.
- R2: With key 0, the protection code `{pte_pp0, pte_pp}` grants read+write+execute for codes 0, 1 and 2, read+execute for codes 3 and 6, and nothing for codes 4, 5 and 7.
- R3: With key 1, the protection code grants read+write+execute for code 2, read+execute for codes 1 and 3, and nothing for codes 0, 4, 5, 6 and 7.
- R4: Any of `pte_nx`, `pte_grd` or `seg_nx` removes the execute right. None of them affects read or write.
- R5: Key masks apply only when `key_prot_en` is 1. For key k, the pair is `amr[63-2k]` (removes write) and `amr[62-2k]` (removes read).
- R6: When `key_prot_en` and `arch_new` are both 1, bit `iamr[62-2k]` removes execute. When `arch_new` is 0, `iamr` has no effect.
- R7: Granted rights are the AND of the three sources. `fault` is 1 exactly when the right needed by `acc_kind` is missing. `acc_kind` codes: 0 = fetch (needs execute), 1 = load (needs read), 2 = store (needs write), 3 = load.
- R8: On a fetch fault, `flt_noexec` is set if the no-execute/guard source refused execute. Otherwise `flt_prot` is set if the protection code refused it. `flt_ikey` is set if the instruction mask refused it. `flt_store` and `flt_dkey` stay 0.
- R9: On a load or store fault, `flt_prot` is set if the protection code refused the needed right. `flt_store` is set on stores. `flt_dkey` is set if the access mask refused the needed right. `flt_noexec` and `flt_ikey` stay 0.
- R10: A fetch with `seg_nx` set always faults with `flt_noexec` set.
- R11: Without a fault, `want_ref` is 1 when `pte_ref` is 0, and `want_chg` is 1 for a store when `pte_chg` is 0. Both are 0 on a fault. When `pte_chg` is 0 and the access is not a store, `wr_ok` is forced to 0.
- R12: All outputs are registered. They take their new values one clock after `req_valid` is high and hold while it is low. `rsp_valid` is `req_valid` delayed one clock. Reset clears every output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| prob_state | input | 1 | Access made in problem (user) state |
| seg_ks | input | 1 | Segment key for privileged state |
| seg_kp | input | 1 | Segment key for problem state |
| seg_nx | input | 1 | Segment no-execute |
| pte_pp0 | input | 1 | Top bit of protection code |
| pte_pp | input | 2 | Low bits of protection code |
| pte_nx | input | 1 | Entry no-execute |
| pte_grd | input | 1 | Entry guarded |
| pte_key | input | KEY_BITS | Entry key selecting the mask pair |
| pte_ref | input | 1 | Entry referenced bit |
| pte_chg | input | 1 | Entry changed bit |
| amr | input | 2<<KEY_BITS | Access mask register |
| iamr | input | 2<<KEY_BITS | Instruction access mask register |
| key_prot_en | input | 1 | Key-mask protection enabled |
| arch_new | input | 1 | Newer architecture level, enables instruction mask |
| acc_kind | input | 2 | Access kind |
| rsp_valid | output | 1 | Response valid |
| rd_ok | output | 1 | Read granted |
| wr_ok | output | 1 | Write granted |
| ex_ok | output | 1 | Execute granted |
| fault | output | 1 | Access refused |
| flt_noexec | output | 1 | Refused by no-execute/guard |
| flt_prot | output | 1 | Refused by protection code |
| flt_store | output | 1 | Faulting access was a store |
| flt_dkey | output | 1 | Refused by access mask |
| flt_ikey | output | 1 | Refused by instruction mask |
| want_ref | output | 1 | Request to set referenced bit |
| want_chg | output | 1 | Request to set changed bit |

## Verification
The assertions assume that the request fields are stable and known in any cycle where `req_valid` is high. They also assume that reset is held for at least one clock edge. They place no limit on how often requests arrive. The bench drives every field at the falling edge and holds it through the next rising edge. It issues back-to-back and idle-separated requests. Random requests draw `acc_kind` only from the three defined kinds, while a directed case covers code 3.

// File: rtl/page_rights_eval.sv
module page_rights_eval #(
  parameter int KEY_BITS = 5
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         req_valid,
  input  logic                         prob_state,
  input  logic                         seg_ks,
  input  logic                         seg_kp,
  input  logic                         seg_nx,
  input  logic                         pte_pp0,
  input  logic [1:0]                   pte_pp,
  input  logic                         pte_nx,
  input  logic                         pte_grd,
  input  logic [KEY_BITS-1:0]          pte_key,
  input  logic                         pte_ref,
  input  logic                         pte_chg,
  input  logic [(2<<KEY_BITS)-1:0]     amr,
  input  logic [(2<<KEY_BITS)-1:0]     iamr,
  input  logic                         key_prot_en,
  input  logic                         arch_new,
  input  logic [1:0]                   acc_kind,
  output logic                         rsp_valid,
  output logic                         rd_ok,
  output logic                         wr_ok,
  output logic                         ex_ok,
  output logic                         fault,
  output logic                         flt_noexec,
  output logic                         flt_prot,
  output logic                         flt_store,
  output logic                         flt_dkey,
  output logic                         flt_ikey,
  output logic                         want_ref,
  output logic                         want_chg
);
  localparam int SLOTS  = 1 << KEY_BITS;
  localparam int MASK_W = 2 * SLOTS;

  logic                use_k;
  logic [2:0]          ppv;
  logic [2:0]          pp_rwx;
  logic                nx_ok;
  logic [KEY_BITS-1:0] slot;
  logic [MASK_W-1:0]   amr_sh, iamr_sh;
  logic                key_r_ok, key_w_ok, key_x_ok;
  logic                is_fetch, is_store;
  logic                g_r, g_w, g_x, deny;
  logic                n_ng, n_prot, n_store, n_dkey, n_ikey, n_ref, n_chg, n_w;

  assign use_k = prob_state ? seg_kp : seg_ks;
  assign ppv   = {pte_pp0, pte_pp};

  always_comb begin
    pp_rwx = 3'b000;
    if (!use_k) begin
      case (ppv)
        3'd0, 3'd1, 3'd2: pp_rwx = 3'b111;
        3'd3, 3'd6:       pp_rwx = 3'b101;
        default:          pp_rwx = 3'b000;
      endcase
    end else begin
      case (ppv)
        3'd2:       pp_rwx = 3'b111;
        3'd1, 3'd3: pp_rwx = 3'b101;
        default:    pp_rwx = 3'b000;
      endcase
    end
  end

  assign nx_ok = !(pte_nx || pte_grd || seg_nx);

  assign slot    = ~pte_key;
  assign amr_sh  = amr  >> {slot, 1'b0};
  assign iamr_sh = iamr >> {slot, 1'b0};

  assign key_r_ok = !(key_prot_en && amr_sh[0]);
  assign key_w_ok = !(key_prot_en && amr_sh[1]);
  assign key_x_ok = !(key_prot_en && arch_new && iamr_sh[0]);

  assign is_fetch = (acc_kind == 2'b00);
  assign is_store = (acc_kind == 2'b10);

  assign g_r = pp_rwx[2] && key_r_ok;
  assign g_w = pp_rwx[1] && key_w_ok;
  assign g_x = pp_rwx[0] && nx_ok && key_x_ok;

  assign deny = is_fetch ? !g_x : (is_store ? !g_w : !g_r);

  assign n_ng    = deny && is_fetch && !nx_ok;
  assign n_prot  = deny && (is_fetch ? (nx_ok && !pp_rwx[0])
                                     : (is_store ? !pp_rwx[1] : !pp_rwx[2]));
  assign n_store = deny && is_store;
  assign n_dkey  = deny && !is_fetch && (is_store ? !key_w_ok : !key_r_ok);
  assign n_ikey  = deny && is_fetch && !key_x_ok;
  assign n_ref   = !deny && !pte_ref;
  assign n_chg   = !deny && is_store && !pte_chg;
  assign n_w     = g_w && (pte_chg || is_store);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rd_ok      <= 1'b0;
      wr_ok      <= 1'b0;
      ex_ok      <= 1'b0;
      fault      <= 1'b0;
      flt_noexec <= 1'b0;
      flt_prot   <= 1'b0;
      flt_store  <= 1'b0;
      flt_dkey   <= 1'b0;
      flt_ikey   <= 1'b0;
      want_ref   <= 1'b0;
      want_chg   <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rd_ok      <= g_r;
        wr_ok      <= n_w;
        ex_ok      <= g_x;
        fault      <= deny;
        flt_noexec <= n_ng;
        flt_prot   <= n_prot;
        flt_store  <= n_store;
        flt_dkey   <= n_dkey;
        flt_ikey   <= n_ikey;
        want_ref   <= n_ref;
        want_chg   <= n_chg;
      end
    end
  end
endmodule

// File: rtl/page_rights_eval_chk.sv
module page_rights_eval_chk #(
  parameter int KEY_BITS = 5
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     req_valid,
  input logic                     prob_state,
  input logic                     seg_ks,
  input logic                     seg_kp,
  input logic                     seg_nx,
  input logic                     pte_pp0,
  input logic [1:0]               pte_pp,
  input logic                     pte_nx,
  input logic                     pte_grd,
  input logic [KEY_BITS-1:0]      pte_key,
  input logic                     pte_ref,
  input logic                     pte_chg,
  input logic [(2<<KEY_BITS)-1:0] amr,
  input logic [(2<<KEY_BITS)-1:0] iamr,
  input logic                     key_prot_en,
  input logic                     arch_new,
  input logic [1:0]               acc_kind,
  input logic                     rsp_valid,
  input logic                     rd_ok,
  input logic                     wr_ok,
  input logic                     ex_ok,
  input logic                     fault,
  input logic                     flt_noexec,
  input logic                     flt_prot,
  input logic                     flt_store,
  input logic                     flt_dkey,
  input logic                     flt_ikey,
  input logic                     want_ref,
  input logic                     want_chg
);
  a_r12_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> $stable({rd_ok, wr_ok, ex_ok, fault, flt_noexec, flt_prot,
                            flt_store, flt_dkey, flt_ikey, want_ref, want_chg}));

  a_r4_nx_blocks_exec: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && (pte_nx || pte_grd || seg_nx) |=> !ex_ok);

  a_r10_seg_nx_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && seg_nx && acc_kind == 2'b00 |=> fault && flt_noexec);

  a_r7_fault_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> (flt_noexec || flt_prot || flt_dkey || flt_ikey));

  a_r8_cause_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(flt_noexec && flt_prot));

  a_r9_store_flag: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && acc_kind == 2'b10 |=> flt_store == fault);

  a_r11_no_update_on_fault: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> !want_ref && !want_chg);

  a_r11_chg_only_store: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && acc_kind != 2'b10 |=> !want_chg);
endmodule

bind page_rights_eval page_rights_eval_chk #(.KEY_BITS(KEY_BITS)) u_chk (.*);

// File: tb/sim_page_rights_eval.sv
module sim_page_rights_eval;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        prob_state, seg_ks, seg_kp, seg_nx, pte_pp0;
  logic [1:0]  pte_pp;
  logic        pte_nx, pte_grd;
  logic [4:0]  pte_key;
  logic        pte_ref, pte_chg;
  logic [63:0] amr, iamr;
  logic        key_prot_en, arch_new;
  logic [1:0]  acc_kind;
  logic        rsp_valid, rd_ok, wr_ok, ex_ok, fault, flt_noexec, flt_prot;
  logic        flt_store, flt_dkey, flt_ikey, want_ref, want_chg;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  page_rights_eval u0 (.*);

  function automatic logic [10:0] model();
    logic k, ex_src, kr, kw, kx, pr, pw, px, gr, gw, gx, f, fe, st;
    logic [2:0] p;
    logic [63:0] a, ia;
    logic [10:0] o;
    k = prob_state ? seg_kp : seg_ks;
    p = {pte_pp0, pte_pp};
    if (!k) {pr, pw, px} = (p <= 3'd2) ? 3'b111 : ((p == 3'd3 || p == 3'd6) ? 3'b101 : 3'b000);
    else    {pr, pw, px} = (p == 3'd2) ? 3'b111 : ((p == 3'd1 || p == 3'd3) ? 3'b101 : 3'b000);
    ex_src = !(pte_nx | pte_grd | seg_nx);
    a  = amr  >> (2 * (31 - int'(pte_key)));
    ia = iamr >> (2 * (31 - int'(pte_key)));
    kr = !(key_prot_en && a[0]);
    kw = !(key_prot_en && a[1]);
    kx = !(key_prot_en && arch_new && ia[0]);
    gr = pr & kr; gw = pw & kw; gx = px & ex_src & kx;
    fe = (acc_kind == 2'd0);
    st = (acc_kind == 2'd2);
    f  = fe ? !gx : (st ? !gw : !gr);
    o = '0;
    o[10] = gr;
    o[9]  = gw & !(!pte_chg && !st);
    o[8]  = gx;
    o[7]  = f;
    if (f && fe) begin
      o[6] = !ex_src;
      o[5] = ex_src & !px;
      o[2] = !kx;
    end else if (f) begin
      o[5] = st ? !pw : !pr;
      o[4] = st;
      o[3] = st ? !kw : !kr;
    end else begin
      o[1] = !pte_ref;
      o[0] = st & !pte_chg;
    end
    return o;
  endfunction

  function automatic logic [10:0] outs();
    return {rd_ok, wr_ok, ex_ok, fault, flt_noexec, flt_prot, flt_store,
            flt_dkey, flt_ikey, want_ref, want_chg};
  endfunction

  task automatic check(input string tag, input logic [11:0] act, input logic [11:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic defaults();
    prob_state = 0; seg_ks = 0; seg_kp = 0; seg_nx = 0; pte_pp0 = 0; pte_pp = 2'd0;
    pte_nx = 0; pte_grd = 0; pte_key = 5'd0; pte_ref = 1; pte_chg = 1;
    amr = '0; iamr = '0; key_prot_en = 0; arch_new = 0; acc_kind = 2'd1;
  endtask

  task automatic run(input string tag);
    logic [10:0] e;
    e = model();
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check(tag, {rsp_valid, outs()}, {1'b1, e});
  endtask

  task automatic set_pp(input int v);
    pte_pp0 = v[2]; pte_pp = v[1:0];
  endtask

  initial begin
    int seed;
    logic [10:0] held;
    seed = $urandom(32'h5eed1234);
    defaults();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R12 reset", {rsp_valid, outs()}, 12'd0);

    for (int v = 0; v < 8; v++) begin
      defaults(); set_pp(v);
      for (int a = 0; a < 3; a++) begin acc_kind = a[1:0]; run("R2 key0 decode"); end
      seg_ks = 1;
      for (int a = 0; a < 3; a++) begin acc_kind = a[1:0]; run("R3 key1 decode"); end
    end

    defaults(); set_pp(0); prob_state = 1; seg_kp = 1; seg_ks = 0; acc_kind = 2'd1;
    run("R1 problem state uses Kp");
    check("R1 user key1 pp0 load", {1'b0, fault}, 2'b01);
    prob_state = 0; run("R1 privileged uses Ks");
    check("R1 priv key0 pp0 load", {1'b0, fault}, 2'b00);

    defaults(); pte_grd = 1; acc_kind = 2'd2; run("R4 guard keeps write");
    check("R4 guard rights", {1'b0, rd_ok, wr_ok, ex_ok}, 4'b0110);
    acc_kind = 2'd0; run("R4 guard denies fetch");

    defaults(); pte_key = 5'd3; amr[63-6] = 1'b1; acc_kind = 2'd2;
    run("R5 amr ignored when disabled");
    key_prot_en = 1; run("R5 amr removes write");
    check("R5 dkey flag", {1'b0, flt_dkey, wr_ok}, 2'b10);
    amr = '0; amr[62-6] = 1'b1; acc_kind = 2'd1; run("R5 amr removes read");

    defaults(); pte_key = 5'd31; iamr[0] = 1'b1; key_prot_en = 1; acc_kind = 2'd0;
    run("R6 iamr ignored on old level");
    check("R6 old level exec", {1'b0, ex_ok}, 2'b01);
    arch_new = 1; run("R6 iamr removes exec");
    check("R6 ikey flag", {1'b0, flt_ikey}, 2'b01);

    defaults(); seg_nx = 1; acc_kind = 2'd0; run("R10 segment no-exec fetch");
    check("R10 seg nx flags", {1'b0, fault, flt_noexec}, 3'b011);

    defaults(); set_pp(3); seg_ks = 1; acc_kind = 2'd0; pte_nx = 0; run("R8 fetch ok key1 pp3");
    set_pp(4); run("R8 fetch prot fault");
    defaults(); set_pp(3); acc_kind = 2'd2; run("R9 store prot fault");
    acc_kind = 2'd3; run("R7 code 3 acts as load");

    defaults(); pte_ref = 0; pte_chg = 0; acc_kind = 2'd1; run("R11 load no C");
    check("R11 write removed", {1'b0, wr_ok, want_ref, want_chg}, 4'b0010);
    acc_kind = 2'd2; run("R11 store sets C");
    check("R11 store requests", {1'b0, want_ref, want_chg}, 3'b011);

    held = outs();
    defaults(); set_pp(7); acc_kind = 2'd0;
    @(negedge clk);
    check("R12 hold when idle", {rsp_valid, outs()}, {1'b0, held});

    for (int i = 0; i < 600; i++) begin
      prob_state = $urandom; seg_ks = $urandom; seg_kp = $urandom;
      seg_nx = ($urandom % 8) == 0; pte_pp0 = $urandom; pte_pp = $urandom;
      pte_nx = ($urandom % 6) == 0; pte_grd = ($urandom % 6) == 0;
      pte_key = $urandom; pte_ref = $urandom; pte_chg = $urandom;
      amr = {$urandom, $urandom}; iamr = {$urandom, $urandom};
      key_prot_en = $urandom; arch_new = $urandom; acc_kind = 2'($urandom % 3);
      run("R7 random");
      if (($urandom % 4) == 0) @(negedge clk);
    end

    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL R12 watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule